// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a serial memory slave on a two-wire bus of clock and data lines. It brings both lines into the core clock domain, finds START and STOP conditions and shifts in the first byte of each transaction. That byte carries a four-bit device type, three device-select bits and an operation bit. When the type equals the configured value and the select bits equal the levels on the strap inputs, the slave acknowledges. It then acknowledges every written byte and hands it to a memory controller through a one-cycle strobe. In read transactions it shifts controller-supplied bytes out most significant bit first.

A write that delivers at least one data byte after the word address and is closed by a STOP raises a one-cycle commit strobe. This starts an internal timer that stands in for the nonvolatile programming time. While the timer runs, the slave does not drive the data line at all, not even to acknowledge its own address. A master can therefore poll with repeated address bytes of either operation until an acknowledge comes back. The pad is modelled only as an output enable that pulls the data line low.

Top module: `twsl_front`

## Requirements
- R1: After reset the data-line enable, the busy flag and all strobes are low.
- R2: A first byte whose bits 7..4 are 1010 and whose bits 3..1 equal the strap inputs (bit 3 against the strap MSB) is acknowledged while the slave is idle. The acknowledge is the data line pulled low for the ninth clock pulse.
- R3: A first byte that differs in the type field or in any select bit gets no acknowledge. No byte strobe follows it until the next START.
- R4: In a write (bit 0 of the first byte is 0), each further byte is received MSB first and acknowledged. Each is presented once on the byte output with a strobe. The first of them is flagged as the word address and the rest are flagged as data.
- R5: A STOP that follows at least one data byte of a write raises a one-cycle commit. The busy flag then stays high for exactly WR_CYCLES clock cycles.
- R6: While busy, a matching first byte with either operation bit gets no acknowledge, and no byte strobe is raised.
- R7: Once busy has dropped, a matching first byte with either operation bit is acknowledged again.
- R8: In a read (bit 0 is 1), the slave drives the read-data input MSB first after the address acknowledge. A master acknowledge after a byte pulses the next-byte request and starts the following byte. A master non-acknowledge releases the line.
- R9: A START or STOP in the middle of a byte abandons the transfer. No byte strobe and no commit result from it, and a START restarts address reception.
- R10: A write closed by STOP after only the word address, or with no byte after the first, produces no commit and leaves the slave not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Device-select strap levels |
| rd_data_i | input | 8 | Byte to send in a read, from the memory controller |
| sda_oe_o | output | 1 | Pull the data line low when high |
| busy_o | output | 1 | Internal write cycle running |
| byte_o | output | 8 | Last received byte of a write |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |
| byte_is_addr_o | output | 1 | byte_o is the word address |
| commit_o | output | 1 | One-cycle strobe: write closed, cycle starts |
| rd_next_o | output | 1 | Master acknowledged a read byte; present the next |

## Verification
The hardest situation to reach is a poll that lands inside the internal write cycle. A master must complete a write with data and a STOP, then start a new address byte before the timer expires. The bench shortens the cycle through the parameter and issues polls of both operation types right after the STOP. It confirms they go unanswered and that no byte strobe leaks out. It then waits for busy to fall and polls again. Mid-byte aborts are produced by tasks that send a partial byte and then a STOP or a repeated START.

// File: rtl/twsl_pkg.sv
package twsl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } twsl_state_e;
endpackage

// File: rtl/twsl_sync.sv
module twsl_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 2) $error("twsl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '1;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '1;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/twsl_cond.sv
module twsl_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/twsl_busy.sv
module twsl_busy #(
   parameter int WR_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);
   localparam int CW = $clog2(WR_CYCLES + 1);

   initial begin
      if (WR_CYCLES < 1) $error("twsl_busy: WR_CYCLES must be positive");
   end

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           left <= '0;
      else if (go)          left <= CW'(WR_CYCLES);
      else if (left != '0)  left <= left - 1'b1;

   assign busy = (left != '0);
endmodule

// File: rtl/twsl_front.sv
module twsl_front
   import twsl_pkg::*;
#(
   parameter int         DW          = 8,
   parameter int         STRAP_W     = 3,
   parameter logic [3:0] DEV_TYPE    = 4'b1010,
   parameter int         SYNC_STAGES = 2,
   parameter int         WR_CYCLES   = 250000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [DW-1:0]      rd_data_i,
   output logic               sda_oe_o,
   output logic               busy_o,
   output logic [DW-1:0]      byte_o,
   output logic               byte_vld_o,
   output logic               byte_is_addr_o,
   output logic               commit_o,
   output logic               rd_next_o
);
   localparam int TYPE_W = DW - 1 - STRAP_W;
   localparam int CNT_W  = $clog2(DW + 1);

   initial begin
      if (TYPE_W != 4) $error("twsl_front: DW - 1 - STRAP_W must equal 4");
      if (DW < 4)      $error("twsl_front: DW too small");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   twsl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
   );

   twsl_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twsl_busy #(.WR_CYCLES(WR_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .go(commit_o), .busy(busy_o)
   );

   twsl_state_e      state;
   logic [CNT_W-1:0] cnt;
   logic [DW-1:0]    sr, tx_sr;
   logic             rw, first, got_data, macked;
   logic             match;

   assign match = (sr[DW-1 -: TYPE_W] == DEV_TYPE) &&
                  (sr[STRAP_W:1] == strap_i) && !busy_o;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state          <= ST_IDLE;
         cnt            <= '0;
         sr             <= '0;
         tx_sr          <= '0;
         rw             <= 1'b0;
         first          <= 1'b0;
         got_data       <= 1'b0;
         macked         <= 1'b0;
         sda_oe_o       <= 1'b0;
         byte_o         <= '0;
         byte_vld_o     <= 1'b0;
         byte_is_addr_o <= 1'b0;
         commit_o       <= 1'b0;
         rd_next_o      <= 1'b0;
      end else begin
         byte_vld_o <= 1'b0;
         commit_o   <= 1'b0;
         rd_next_o  <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_det) begin
            if (state == ST_RX && !rw && got_data && cnt <= CNT_W'(1))
               commit_o <= 1'b1;
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     sr  <= {sr[DW-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_W'(DW)) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (match) begin
                           sda_oe_o <= 1'b1;
                           rw       <= sr[0];
                           first    <= 1'b1;
                           got_data <= 1'b0;
                           state    <= ST_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        sda_oe_o       <= 1'b1;
                        byte_o         <= sr;
                        byte_is_addr_o <= first;
                        byte_vld_o     <= 1'b1;
                        if (!first) got_data <= 1'b1;
                        first          <= 1'b0;
                        state          <= ST_ACK;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        tx_sr    <= rd_data_i;
                        sda_oe_o <= ~rd_data_i[DW-1];
                        state    <= ST_TX;
                     end else begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == CNT_W'(DW - 1)) begin
                        sda_oe_o <= 1'b0;
                        macked   <= 1'b0;
                        state    <= ST_MACK;
                     end else begin
                        tx_sr    <= tx_sr << 1;
                        sda_oe_o <= ~tx_sr[DW-2];
                        cnt      <= cnt + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     if (!sda_s) begin
                        macked    <= 1'b1;
                        rd_next_o <= 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (scl_fall && macked) begin
                     cnt      <= '0;
                     tx_sr    <= rd_data_i;
                     sda_oe_o <= ~rd_data_i[DW-1];
                     state    <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
endmodule

// File: rtl/twsl_front_chk.sv
module twsl_front_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe_o,
   input logic busy_o,
   input logic byte_vld_o,
   input logic commit_o,
   input logic rd_next_o
);
   AST_ACK_SCL_LOW:   assert property (@(posedge clk) disable iff (!rst_n)
                         $rose(sda_oe_o) |-> !scl_i);                  // R2
   AST_VLD_ONE_CYC:   assert property (@(posedge clk) disable iff (!rst_n)
                         byte_vld_o |=> !byte_vld_o);                  // R4
   AST_COMMIT_BUSY:   assert property (@(posedge clk) disable iff (!rst_n)
                         commit_o |=> busy_o);                         // R5
   AST_NO_COMMIT_BSY: assert property (@(posedge clk) disable iff (!rst_n)
                         commit_o |-> !busy_o);                        // R5
   AST_QUIET_BUSY:    assert property (@(posedge clk) disable iff (!rst_n)
                         busy_o |-> !byte_vld_o);                      // R6
   AST_RD_NO_WR:      assert property (@(posedge clk) disable iff (!rst_n)
                         rd_next_o |-> !byte_vld_o && !commit_o);      // R8
endmodule

bind twsl_front twsl_front_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
   .busy_o(busy_o), .byte_vld_o(byte_vld_o), .commit_o(commit_o),
   .rd_next_o(rd_next_o)
);

// File: tb/sim_twsl_front.sv
`timescale 1ns/1ps
module sim_twsl_front;
   localparam int WRC = 2000;
   localparam int Q   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic [2:0] strap = 3'b101;
   logic [7:0] rd_data = 8'h3C;
   logic       sda_oe, busy, byte_vld, byte_is_addr, commit, rd_next;
   logic [7:0] byte_out;
   wire        sda_w = m_sda & ~sda_oe;

   int n_cmp = 0, n_bad = 0, n_commit = 0, n_rdnext = 0, busy_cyc = 0;
   logic timed_out = 1'b0;
   logic [8:0] exp_q[$];

   always #10 clk = ~clk;

   twsl_front #(.WR_CYCLES(WRC)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_w),
      .strap_i(strap), .rd_data_i(rd_data), .sda_oe_o(sda_oe),
      .busy_o(busy), .byte_o(byte_out), .byte_vld_o(byte_vld),
      .byte_is_addr_o(byte_is_addr), .commit_o(commit), .rd_next_o(rd_next)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (byte_vld) begin
         if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {byte_is_addr, byte_out}, 0);
         else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk({byte_is_addr, byte_out} == e, "R4 byte", {byte_is_addr, byte_out}, e);
         end
      end
      if (commit)  n_commit++;
      if (rd_next) n_rdnext++;
   end
   always @(posedge clk) begin
      if (busy) busy_cyc++;
      if (rd_next) rd_data <= 8'hE1;
   end

   task automatic qw(input int n); repeat (n) @(posedge clk); endtask

   task automatic bus_start();
      m_sda = 1'b1; qw(Q); m_scl = 1'b1; qw(Q);
      m_sda = 1'b0; qw(Q); m_scl = 1'b0; qw(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qw(Q); m_scl = 1'b1; qw(Q); m_sda = 1'b1; qw(2*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; qw(Q); m_scl = 1'b1; qw(2*Q); m_scl = 1'b0; qw(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input logic push, input logic is_a,
                            output logic acked);
      if (push) exp_q.push_back({is_a, b});
      send_bits(b, 8);
      m_sda = 1'b1; qw(Q); m_scl = 1'b1; qw(Q);
      @(negedge clk) acked = ~sda_w;
      qw(Q); m_scl = 1'b0; qw(Q);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qw(Q); m_scl = 1'b1; qw(Q);
         @(negedge clk) b[i] = sda_w;
         qw(Q); m_scl = 1'b0; qw(Q);
      end
      m_sda = ~give_ack; qw(Q); m_scl = 1'b1; qw(2*Q); m_scl = 1'b0; qw(Q);
      m_sda = 1'b1;
   endtask

   task automatic run_all();
      logic a;
      logic [7:0] rb;
      // R1 reset state
      qw(5);
      @(negedge clk);
      chk(sda_oe == 0, "R1 oe", sda_oe, 0);
      chk(busy == 0, "R1 busy", busy, 0);
      chk(byte_vld == 0 && commit == 0 && rd_next == 0, "R1 strobes",
          {byte_vld, commit, rd_next}, 0);
      rst_n = 1'b1; qw(5);

      // R2 R4 R5: write with two data bytes
      bus_start();
      send_byte(8'hAA, 0, 0, a); chk(a, "R2 addr ack", a, 1);
      send_byte(8'h12, 1, 1, a); chk(a, "R4 word ack", a, 1);
      send_byte(8'h5C, 1, 0, a); chk(a, "R4 data ack", a, 1);
      send_byte(8'hA3, 1, 0, a); chk(a, "R4 data ack", a, 1);
      bus_stop();
      @(negedge clk);
      chk(n_commit == 1, "R5 commit", n_commit, 1);
      chk(busy == 1, "R5 busy", busy, 1);

      // R6 poll while busy, both operations
      bus_start();
      send_byte(8'hAA, 0, 0, a); chk(!a, "R6 write poll nack", a, 0);
      send_byte(8'h77, 0, 0, a); chk(!a, "R6 no byte ack", a, 0);
      bus_stop();
      bus_start();
      send_byte(8'hAB, 0, 0, a); chk(!a, "R6 read poll nack", a, 0);
      bus_stop();
      chk(busy == 1, "R6 still busy", busy, 1);

      // R7 poll after completion
      wait (busy == 0); qw(4);
      chk(busy_cyc == WRC, "R5 busy length", busy_cyc, WRC);
      bus_start();
      send_byte(8'hAB, 0, 0, a); chk(a, "R7 read poll ack", a, 1);
      recv_byte(1'b0, rb);
      bus_stop();
      bus_start();
      send_byte(8'hAA, 0, 0, a); chk(a, "R7 write poll ack", a, 1);
      bus_stop();
      @(negedge clk);
      chk(n_commit == 1 && busy == 0, "R10 no commit on empty write", n_commit, 1);

      // R3 mismatches
      bus_start();
      send_byte(8'hA2, 0, 0, a); chk(!a, "R3 strap mismatch", a, 0);
      send_byte(8'h33, 0, 0, a); chk(!a, "R3 ignored byte", a, 0);
      bus_stop();
      bus_start();
      send_byte(8'hBA, 0, 0, a); chk(!a, "R3 type mismatch", a, 0);
      bus_stop();

      // R8 read two bytes
      rd_data = 8'h3C;
      bus_start();
      send_byte(8'hAB, 0, 0, a); chk(a, "R8 read addr ack", a, 1);
      recv_byte(1'b1, rb); chk(rb == 8'h3C, "R8 first byte", rb, 8'h3C);
      chk(n_rdnext == 1, "R8 next request", n_rdnext, 1);
      recv_byte(1'b0, rb); chk(rb == 8'hE1, "R8 second byte", rb, 8'hE1);
      chk(n_rdnext == 1, "R8 no request on nack", n_rdnext, 1);
      @(negedge clk);
      chk(sda_oe == 0, "R8 line released", sda_oe, 0);
      bus_stop();

      // R9 aborts mid-byte
      bus_start();
      send_byte(8'hAA, 0, 0, a); chk(a, "R9 setup ack", a, 1);
      send_byte(8'h20, 1, 1, a);
      send_bits(8'hF0, 4);
      bus_stop();
      @(negedge clk);
      chk(n_commit == 1 && busy == 0, "R9 stop mid-byte no commit", n_commit, 1);
      bus_start();
      send_bits(8'hAA, 4);
      bus_start();
      send_byte(8'hAA, 0, 0, a); chk(a, "R9 restart ack", a, 1);
      send_byte(8'h40, 1, 1, a); chk(a, "R10 word ack", a, 1);
      bus_stop();
      @(negedge clk);
      chk(n_commit == 1 && busy == 0, "R10 address only no commit", n_commit, 1);
      qw(10);
      chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
   endtask

   initial begin
      fork
         run_all();
         begin qw(150000); timed_out = 1'b1; end
      join_any
      disable fork;
      if (timed_out) chk(1'b0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule